// File: doc/BRIEF.md
# UART DMA Ready Handshake Generator

This block drives the two active-low handshake lines that tell an external DMA engine when the UART receive side has bytes worth collecting and when the transmit side can take more bytes. It watches the fill counts of both FIFOs, the transmit-full flag and a receive timeout pulse. The FIFOs and the timeout counter that produce these inputs are outside the block. It also keeps the three FIFO control settings it needs: the FIFO enable, the transfer-mode select and the receive threshold selection. These are captured from writes to the FIFO control byte.

There are two signalling styles. Single-transfer style reports simple occupancy: receive-ready means at least one byte is waiting, and transmit-ready means the transmit side is empty. Block-transfer style is used for bursts. Receive-ready asserts once the threshold is met or a timeout occurs, then stays asserted until the receive FIFO is drained. Transmit-ready is withdrawn only while the transmit FIFO is full. Both outputs are registered, so they change cleanly one clock after their cause.

Top module: `dma_rdy`

## Requirements
- R1: While reset is high, and in the first cycle after it, both ready outputs are 1. Reset clears all stored control settings, which selects single-transfer style.
- R2: On a control write, bit 0 (FIFO enable) is always stored. Bit 3 (mode) and bits 7:6 (threshold) are stored only when bit 0 of the same write is 1. A write governs the outputs from the second clock edge after it.
- R3: Block-transfer style is active only when the stored mode bit and the stored FIFO enable are both 1. In every other case, single-transfer style applies.
- R4: In single-transfer style, the receive-ready output is 0 when the receive count is nonzero and 1 when it is zero.
- R5: In block-transfer style, the receive-ready output goes to 0 when the receive count is at or above the threshold, or when the timeout input is 1 while the count is nonzero.
- R6: In block-transfer style, once the receive-ready output is 0 it stays 0 while the count is nonzero, even below the threshold. Once it is 1 it stays 1 below the threshold with no timeout. A zero count forces it to 1, and this overrides a timeout in the same cycle.
- R7: The threshold field in bits 7:6 selects 1 byte (00), 4 (01), 8 (10) or 14 (11), for a FIFO depth of 16.
- R8: In single-transfer style, the transmit-ready output is 0 when the transmit count is zero and 1 once any byte is held.
- R9: In block-transfer style, the transmit-ready output equals the transmit-full input: 1 only when full, 0 when any slot is free.
- R10: Each output is a flop, so it reflects the inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fcrWe | input | 1 | Write strobe for the FIFO control byte |
| fcrData | input | 8 | FIFO control byte being written |
| rxCount | input | 5 | Bytes held in the receive FIFO |
| rxTimeout | input | 1 | Receive timeout indication |
| txCount | input | 5 | Bytes held in the transmit FIFO or holding register |
| txFull | input | 1 | Transmit FIFO full |
| rxRdyN | output | 1 | Receive ready, active low |
| txRdyN | output | 1 | Transmit ready, active low |

## Verification
Two events can fall in the same cycle. One is a receive timeout arriving exactly as the receive count reaches zero. The test provokes this, and R6 decides the outcome: the empty count must win, so receive-ready is expected high.

The other is a control write that changes the mode while the counts also move in that same cycle. Because R2 delays new settings by one cycle, the result of that edge is judged against the old style, and the new style is judged only from the following cycle.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;
  // Settings handed from the control register block to the datapath
  typedef struct packed {
    logic       blockMode;  // block-transfer signalling in force
    logic [1:0] trigSel;    // receive threshold selector
  } rdyCtrlT;
endpackage

// File: rtl/dma_rdy_ctrl.sv
module dma_rdy_ctrl
  import dma_rdy_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fcrWe,
  input  logic [7:0] fcrData,
  output rdyCtrlT    ctrl
);
  localparam int EN_BIT   = 0;
  localparam int MODE_BIT = 3;
  localparam int TRIG_LO  = 6;

  logic       fifoEnQ;
  logic       modeQ;
  logic [1:0] trigQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifoEnQ <= 1'b0;
      modeQ   <= 1'b0;
      trigQ   <= 2'b00;
    end else if (fcrWe) begin
      fifoEnQ <= fcrData[EN_BIT];
      // the remaining fields are accepted only alongside the enable bit
      if (fcrData[EN_BIT]) begin
        modeQ <= fcrData[MODE_BIT];
        trigQ <= fcrData[TRIG_LO +: 2];
      end
    end
  end

  always_comb begin
    ctrl.blockMode = fifoEnQ & modeQ;
    ctrl.trigSel   = trigQ;
  end
endmodule

// File: rtl/dma_rdy_dpath.sv
module dma_rdy_dpath
  import dma_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  rdyCtrlT       ctrl,
  input  logic [CW-1:0] rxCount,
  input  logic          rxTimeout,
  input  logic [CW-1:0] txCount,
  input  logic          txFull,
  output logic          rxRdyN,
  output logic          txRdyN
);
  localparam int NLVL = 4;
  localparam int LVLS [NLVL] = '{LVL0, LVL1, LVL2, LVL3};

  logic [NLVL-1:0] reachVec;
  logic rxEmpty, txEmpty, rxReach;
  logic rxRdyNQ, txRdyNQ;

  // one threshold comparator per selectable level
  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    assign reachVec[i] = (rxCount >= CW'(LVLS[i]));
  end

  assign rxReach = reachVec[ctrl.trigSel];
  assign rxEmpty = (rxCount == '0);
  assign txEmpty = (txCount == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rxRdyNQ <= 1'b1;
    end else if (!ctrl.blockMode) begin
      rxRdyNQ <= rxEmpty;
    end else if (rxEmpty) begin
      rxRdyNQ <= 1'b1;
    end else if (rxReach || rxTimeout) begin
      rxRdyNQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) txRdyNQ <= 1'b1;
    else     txRdyNQ <= ctrl.blockMode ? txFull : !txEmpty;
  end

  assign rxRdyN = rxRdyNQ;
  assign txRdyN = txRdyNQ;
endmodule

// File: rtl/dma_rdy.sv
module dma_rdy
  import dma_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fcrWe,
  input  logic [7:0]                   fcrData,
  input  logic [$clog2(DEPTH+1)-1:0]   rxCount,
  input  logic                         rxTimeout,
  input  logic [$clog2(DEPTH+1)-1:0]   txCount,
  input  logic                         txFull,
  output logic                         rxRdyN,
  output logic                         txRdyN
);
  rdyCtrlT ctrl;

  dma_rdy_ctrl u_ctrl (
    .clk(clk), .rst(rst), .fcrWe(fcrWe), .fcrData(fcrData), .ctrl(ctrl)
  );

  dma_rdy_dpath #(
    .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_dpath (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .rxCount(rxCount), .rxTimeout(rxTimeout),
    .txCount(txCount), .txFull(txFull),
    .rxRdyN(rxRdyN), .txRdyN(txRdyN)
  );
endmodule

// File: rtl/dma_rdy_chk.sv
module dma_rdy_chk
  import dma_rdy_pkg::*;
#(
  parameter int CW   = 5,
  parameter int LVL0 = 1,
  parameter int LVL1 = 4,
  parameter int LVL2 = 8,
  parameter int LVL3 = 14
) (
  input logic          clk,
  input logic          rst,
  input rdyCtrlT       ctrl,
  input logic [CW-1:0] rxCount,
  input logic          rxTimeout,
  input logic [CW-1:0] txCount,
  input logic          txFull,
  input logic          rxRdyN,
  input logic          txRdyN
);
  logic [CW-1:0] selLvl;
  always_comb begin
    case (ctrl.trigSel)
      2'd0:    selLvl = CW'(LVL0);
      2'd1:    selLvl = CW'(LVL1);
      2'd2:    selLvl = CW'(LVL2);
      default: selLvl = CW'(LVL3);
    endcase
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (rxRdyN && txRdyN));

  a_r4_single_rx: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl.blockMode)) |-> (rxRdyN == ($past(rxCount) == '0)));

  a_r8_single_tx: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl.blockMode)) |-> (txRdyN == ($past(txCount) != '0)));

  a_r9_block_tx: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.blockMode)) |-> (txRdyN == $past(txFull)));

  a_r6_empty_release: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.blockMode) && $past(rxCount) == '0) |-> rxRdyN);

  a_r6_hold_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.blockMode) && !$past(rxRdyN) && $past(rxCount) != '0)
      |-> !rxRdyN);

  a_r5_timeout_set: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.blockMode) && $past(rxTimeout) && $past(rxCount) != '0)
      |-> !rxRdyN);

  a_r7_threshold_set: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.blockMode) && $past(rxCount) != '0 &&
     $past(rxCount) >= $past(selLvl)) |-> !rxRdyN);
endmodule

bind dma_rdy dma_rdy_chk #(
  .CW($clog2(DEPTH+1)), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl),
  .rxCount(rxCount), .rxTimeout(rxTimeout),
  .txCount(txCount), .txFull(txFull),
  .rxRdyN(rxRdyN), .txRdyN(txRdyN)
);

// File: tb/dma_rdy_test.sv
module dma_rdy_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fcrWe = 1'b0;
  logic [7:0] fcrData = 8'h00;
  logic [4:0] rxCount = '0;
  logic       rxTimeout = 1'b0;
  logic [4:0] txCount = '0;
  logic       txFull = 1'b0;
  logic       rxRdyN, txRdyN;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  rx;
    logic  tx;
    string tag;
  } expT;
  expT expQ[$];

  // bench model of the stored control settings and receive state
  logic mEn = 1'b0, mMode = 1'b0, mRx = 1'b1;
  logic [1:0] mTrig = 2'b00;

  always #4 clk = ~clk;

  dma_rdy uut (
    .clk(clk), .rst(rst), .fcrWe(fcrWe), .fcrData(fcrData),
    .rxCount(rxCount), .rxTimeout(rxTimeout),
    .txCount(txCount), .txFull(txFull),
    .rxRdyN(rxRdyN), .txRdyN(txRdyN)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvlOf(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  // driver: apply one cycle of stimulus and queue the value expected after the edge
  task automatic step(input logic we, input logic [7:0] d, input int rc,
                      input logic tmo, input int tc, input logic tf, input string tag);
    expT e;
    logic blk;
    @(negedge clk);
    fcrWe = we; fcrData = d; rxCount = 5'(rc); rxTimeout = tmo;
    txCount = 5'(tc); txFull = tf;
    blk = mEn & mMode;
    if (!blk)                          mRx = (rc == 0);
    else if (rc == 0)                  mRx = 1'b1;
    else if (rc >= lvlOf(mTrig) || tmo) mRx = 1'b0;
    e.rx = mRx;
    e.tx = blk ? tf : (tc != 0);
    e.tag = tag;
    expQ.push_back(e);
    if (we) begin
      mEn = d[0];
      if (d[0]) begin mMode = d[3]; mTrig = d[7:6]; end
    end
  endtask

  // monitor: compare design outputs with the queued expectations
  initial begin
    forever begin
      expT e;
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        check({e.tag, " rx"}, rxRdyN, e.rx);
        check({e.tag, " tx"}, txRdyN, e.tx);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset rx", rxRdyN, 1'b1);
    check("R1 reset tx", txRdyN, 1'b1);
    rst = 1'b0;
    // R1: settings cleared, single-transfer style right after reset
    step(0, 8'h00, 0, 0, 0, 0, "R1 idle");
    // R8 single-transfer transmit
    step(0, 8'h00, 0, 0, 1, 0, "R8 loaded");
    step(0, 8'h00, 0, 0, 0, 0, "R8 empty");
    // R4 and R10 single-transfer receive
    step(0, 8'h00, 3, 0, 0, 0, "R4 R10 rx held");
    step(0, 8'h00, 0, 0, 0, 0, "R4 rx drained");
    // R2 and R3: mode bit without enable is dropped
    step(1, 8'h08, 0, 0, 0, 0, "R2 write no enable");
    step(1, 8'h01, 2, 0, 5, 0, "R3 enable only");
    step(0, 8'h00, 2, 0, 5, 0, "R3 still single");
    // R2: enable plus mode, takes effect on the edge after the write
    step(1, 8'h09, 0, 0, 5, 0, "R2 write block");
    step(0, 8'h00, 1, 0, 5, 0, "R7 R5 level 1 reached");
    step(0, 8'h00, 0, 0, 5, 0, "R9 R6 block tx free");
    // threshold 8
    step(1, 8'h89, 0, 0, 16, 1, "R9 tx full");
    step(0, 8'h00, 7, 0, 15, 0, "R6 R7 below 8 stays high");
    step(0, 8'h00, 8, 0, 15, 0, "R7 R5 reach 8");
    step(0, 8'h00, 3, 0, 15, 0, "R6 hold low");
    step(0, 8'h00, 0, 0, 15, 0, "R6 empty release");
    step(0, 8'h00, 2, 1, 15, 0, "R5 timeout");
    step(0, 8'h00, 0, 1, 15, 0, "R6 empty beats timeout");
    // threshold 14
    step(1, 8'hC9, 0, 0, 0, 0, "R7 write 14");
    step(0, 8'h00, 13, 0, 0, 0, "R7 below 14");
    step(0, 8'h00, 14, 0, 0, 0, "R7 reach 14");
    // threshold 4
    step(1, 8'h49, 0, 0, 0, 0, "R7 write 4");
    step(0, 8'h00, 3, 0, 0, 0, "R7 below 4");
    step(0, 8'h00, 4, 0, 0, 0, "R7 reach 4");
    // R3: dropping the enable disables block style even though mode was stored
    step(1, 8'h08, 3, 0, 5, 0, "R3 disable write");
    step(0, 8'h00, 3, 0, 5, 0, "R3 single again");
    step(0, 8'h00, 0, 0, 0, 0, "R3 R8 empty");
    repeat (3) @(posedge clk);
    #3;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule